// File: doc/BRIEF.md
# Three-Channel Match and Overflow Timer

This peripheral holds three independent 32-bit counters behind one word-wide register port. Each counter has a count register that software can load at any time, a reload value applied on wrap, and two compare values. A shared control word sets, for each counter, whether it runs, whether it advances on every system clock or on rising edges of an external tick input, whether it may raise the interrupt, and whether it counts up or down.

Each counter produces three events: a wrap (overflow or underflow), a first compare hit and a second compare hit. The nine events land in one sticky status word. A matching mask word and the per-counter interrupt enables select which events drive the single interrupt line. A periodic tick of period P comes from loading both count and reload with 0xFFFFFFFF − (P − 1) on an up-counter. A one-shot deadline comes from arming a compare value.

The register port carries no data stream. It is a plain strobe interface: a write happens in any cycle with `reg_wr` high, and read data is a combinational function of `reg_addr`. It has no back-pressure.

Top module: `tri_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Counter n (n = 0..2) has count, reload, compare-1 and compare-2 at byte offsets 0x10·n + 0x0/0x4/0x8/0xC. Control is at 0x30 (12 bits), status at 0x34 (9 bits) and mask at 0x38 (9 bits). A written value reads back from the next cycle, truncated to the register width. Any other address reads zero and ignores writes.
- R3: Counter n runs only while control bit 3n is 1. With direction bit 9+n at 1 it adds one per tick.
- R4: On a tick, an up-counter holding 0xFFFFFFFF loads its reload value and sets status bit 3n+2. A reload value of 0xFFFFFFFF − (P − 1) therefore gives one wrap event every P ticks.
- R5: With direction bit 9+n at 0 the counter subtracts one per tick. On a tick while it holds zero, it loads its reload value and sets status bit 3n+2.
- R6: When a tick gives the count a new value equal to compare-1 or compare-2, status bit 3n or 3n+1 is set at that same clock edge.
- R7: A write to a count register takes effect at that clock edge and wins over a tick in the same cycle. It raises no event. Later ticks continue from the written value.
- R8: With control bit 3n+1 at 0, the counter ticks every clock. With it at 1, it ticks once per rising edge of `ext_tick`: if `ext_tick` is first sampled high at edge k, the count changes at edge k+2.
- R9: Status bits stay set until cleared. A write to status clears the bits written as 0 and keeps the bits written as 1. An event in the same cycle as the clear wins.
- R10: `irq` is high exactly when some status bit 3n+j is set, its mask bit is 1, and control bit 3n+2 of its counter is 1.
- R11: A counter that is not enabled, or that has no tick in a cycle, holds its count and raises no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | External tick source, asynchronous |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined interrupt, level |

## Verification
A write, a tick and the events it causes all land at the same rising edge. From that edge on they are visible on `reg_rdata` and `irq`, because both are combinational from register state. An external edge first sampled high at edge k moves the count at edge k+2. The bench steps a behavioural model at each rising edge and compares `reg_rdata` for the driven address, and `irq`, 1 ns after every edge. This places each comparison after the edge at which a result is due and before the next input change at the falling edge.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
  localparam int NCH       = 3;
  localparam int EV_PER_CH = 3;
  localparam int EVW       = NCH * EV_PER_CH;
  localparam int DIR_BASE  = EVW;
  localparam int CTRL_W    = EVW + NCH;

  localparam int CH_STRIDE = 'h10;
  localparam int OFS_CNT   = 'h0;
  localparam int OFS_RLD   = 'h4;
  localparam int OFS_CMP1  = 'h8;
  localparam int OFS_CMP2  = 'hC;
  localparam int OFS_CTRL  = NCH * CH_STRIDE;
  localparam int OFS_STAT  = OFS_CTRL + 4;
  localparam int OFS_MASK  = OFS_CTRL + 8;

  // bit 0 = compare-1, bit 1 = compare-2, bit 2 = wrap
  typedef struct packed {
    logic wrap;
    logic hit2;
    logic hit1;
  } ch_ev_t;
endpackage

// File: rtl/tmr3_tick_sync.sv
module tmr3_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tmr3_channel.sv
module tmr3_channel #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            up_i,
  input  logic            cnt_wr_i,
  input  logic            rld_wr_i,
  input  logic            cmp1_wr_i,
  input  logic            cmp2_wr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   cnt_o,
  output logic [DW-1:0]   rld_o,
  output logic [DW-1:0]   cmp1_o,
  output logic [DW-1:0]   cmp2_o,
  output tmr3_pkg::ch_ev_t ev_o
);
  localparam logic [DW-1:0] ALL1 = '1;

  logic [DW-1:0] cnt_q, rld_q, cmp1_q, cmp2_q, nxt;
  logic          at_end, adv;

  always_comb begin
    at_end = up_i ? (cnt_q == ALL1) : (cnt_q == '0);
    if (at_end)    nxt = rld_q;
    else if (up_i) nxt = cnt_q + DW'(1);
    else           nxt = cnt_q - DW'(1);
  end

  assign adv = tick_i & ~cnt_wr_i;

  assign ev_o.wrap = adv & at_end;
  assign ev_o.hit1 = adv & (nxt == cmp1_q);
  assign ev_o.hit2 = adv & (nxt == cmp2_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      cmp1_q <= '0;
      cmp2_q <= '0;
    end else begin
      if (cnt_wr_i)  cnt_q  <= wdata_i;
      else if (adv)  cnt_q  <= nxt;
      if (rld_wr_i)  rld_q  <= wdata_i;
      if (cmp1_wr_i) cmp1_q <= wdata_i;
      if (cmp2_wr_i) cmp2_q <= wdata_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign cmp1_o = cmp1_q;
  assign cmp2_o = cmp2_q;

  assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_wr_i && up_i && cnt_q != ALL1) |=> cnt_q == $past(cnt_q) + DW'(1));
  assert_up_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_wr_i && up_i && cnt_q == ALL1) |=> cnt_q == $past(rld_q));
  assert_dn_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_wr_i && !up_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - DW'(1));
  assert_dn_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_wr_i && !up_i && cnt_q == '0) |=> cnt_q == $past(rld_q));
  assert_sw_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> cnt_q == $past(wdata_i));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cnt_wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr3_irq_ctrl.sv
module tmr3_irq_ctrl #(
  parameter int NCH = 3,
  parameter int EPC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH*EPC-1:0] ev_i,
  input  logic               st_wr_i,
  input  logic               mask_wr_i,
  input  logic [NCH*EPC-1:0] wdata_i,
  input  logic [NCH-1:0]     ie_i,
  output logic [NCH*EPC-1:0] status_o,
  output logic [NCH*EPC-1:0] mask_o,
  output logic               irq_o
);
  localparam int W = NCH * EPC;

  logic [W-1:0] st_q, mask_q, keep, ie_wide;

  assign keep = st_wr_i ? wdata_i : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      mask_q <= '0;
    end else begin
      st_q <= (st_q & keep) | ev_i;
      if (mask_wr_i) mask_q <= wdata_i;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ie
    assign ie_wide[n*EPC +: EPC] = {EPC{ie_i[n]}};
  end

  assign irq_o    = |(st_q & mask_q & ie_wide);
  assign status_o = st_q;
  assign mask_o   = mask_q;

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr_i |=> (st_q & $past(st_q)) == $past(st_q));
  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> (st_q & $past(ev_i)) == $past(ev_i));
  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (st_q & mask_q) != '0);
endmodule

// File: rtl/tri_timer.sv
module tri_timer #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import tmr3_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic              ext_rise;
  logic [NCH-1:0]    ie, tick;
  logic [EVW-1:0]    ev_all, status, mask;
  logic [DATA_W-1:0] cnt [NCH];
  logic [DATA_W-1:0] rld [NCH];
  logic [DATA_W-1:0] cmp1[NCH];
  logic [DATA_W-1:0] cmp2[NCH];

  wire sel_ctrl = reg_addr == ADDR_W'(OFS_CTRL);
  wire sel_stat = reg_addr == ADDR_W'(OFS_STAT);
  wire sel_mask = reg_addr == ADDR_W'(OFS_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ctrl_q <= '0;
    else if (reg_wr && sel_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  tmr3_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ext_tick),
    .rise_o  (ext_rise)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int B    = n * EV_PER_CH;
    localparam int BASE = n * CH_STRIDE;
    ch_ev_t ch_ev;

    assign tick[n] = ctrl_q[B] & (ctrl_q[B+1] ? ext_rise : 1'b1);
    assign ie[n]   = ctrl_q[B+2];
    assign ev_all[B +: EV_PER_CH] = ch_ev;

    tmr3_channel #(.DW(DATA_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick[n]),
      .up_i      (ctrl_q[DIR_BASE+n]),
      .cnt_wr_i  (reg_wr && reg_addr == ADDR_W'(BASE + OFS_CNT)),
      .rld_wr_i  (reg_wr && reg_addr == ADDR_W'(BASE + OFS_RLD)),
      .cmp1_wr_i (reg_wr && reg_addr == ADDR_W'(BASE + OFS_CMP1)),
      .cmp2_wr_i (reg_wr && reg_addr == ADDR_W'(BASE + OFS_CMP2)),
      .wdata_i   (reg_wdata),
      .cnt_o     (cnt[n]),
      .rld_o     (rld[n]),
      .cmp1_o    (cmp1[n]),
      .cmp2_o    (cmp2[n]),
      .ev_o      (ch_ev)
    );
  end

  tmr3_irq_ctrl #(.NCH(NCH), .EPC(EV_PER_CH)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_i      (ev_all),
    .st_wr_i   (reg_wr && sel_stat),
    .mask_wr_i (reg_wr && sel_mask),
    .wdata_i   (reg_wdata[EVW-1:0]),
    .ie_i      (ie),
    .status_o  (status),
    .mask_o    (mask),
    .irq_o     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NCH; n++) begin
      if (reg_addr == ADDR_W'(n*CH_STRIDE + OFS_CNT))  reg_rdata = cnt[n];
      if (reg_addr == ADDR_W'(n*CH_STRIDE + OFS_RLD))  reg_rdata = rld[n];
      if (reg_addr == ADDR_W'(n*CH_STRIDE + OFS_CMP1)) reg_rdata = cmp1[n];
      if (reg_addr == ADDR_W'(n*CH_STRIDE + OFS_CMP2)) reg_rdata = cmp2[n];
    end
    if (sel_ctrl) reg_rdata = DATA_W'(ctrl_q);
    if (sel_stat) reg_rdata = DATA_W'(status);
    if (sel_mask) reg_rdata = DATA_W'(mask);
  end

  assert_irq_needs_ie_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie != '0);
endmodule

// File: tb/tri_timer_bench.sv
`timescale 1ns/1ps
module tri_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        irq;

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  tri_timer u_tri_timer (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural reference
  logic [31:0] m_cnt[3], m_rld[3], m_c1[3], m_c2[3];
  logic [11:0] m_ctrl;
  logic [8:0]  m_st, m_mask;
  logic        h1, h2, h3;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    for (int n = 0; n < 3; n++) begin
      if (a == 8'(n*16))     return m_cnt[n];
      if (a == 8'(n*16 + 4)) return m_rld[n];
      if (a == 8'(n*16 + 8)) return m_c1[n];
      if (a == 8'(n*16 + 12)) return m_c2[n];
    end
    if (a == 8'h30) return {20'h0, m_ctrl};
    if (a == 8'h34) return {23'h0, m_st};
    if (a == 8'h38) return {23'h0, m_mask};
    return 32'h0;
  endfunction

  function automatic logic m_irq();
    logic r = 1'b0;
    for (int b = 0; b < 9; b++)
      if (m_st[b] && m_mask[b] && m_ctrl[(b/3)*3 + 2]) r = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < 3; n++) begin
        m_cnt[n] = 0; m_rld[n] = 0; m_c1[n] = 0; m_c2[n] = 0;
      end
      m_ctrl = 0; m_st = 0; m_mask = 0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      logic [8:0]  ev;
      logic [31:0] nc[3];
      ev = 0;
      for (int n = 0; n < 3; n++) begin
        bit tk;
        tk = m_ctrl[3*n] && (m_ctrl[3*n+1] ? (h2 && !h3) : 1'b1);
        nc[n] = m_cnt[n];
        if (reg_wr && reg_addr == 8'(n*16)) nc[n] = reg_wdata;
        else if (tk) begin
          if (m_ctrl[9+n]) begin
            if (m_cnt[n] == 32'hFFFF_FFFF) begin nc[n] = m_rld[n]; ev[3*n+2] = 1; end
            else nc[n] = m_cnt[n] + 1;
          end else begin
            if (m_cnt[n] == 0) begin nc[n] = m_rld[n]; ev[3*n+2] = 1; end
            else nc[n] = m_cnt[n] - 1;
          end
          if (nc[n] == m_c1[n]) ev[3*n]   = 1;
          if (nc[n] == m_c2[n]) ev[3*n+1] = 1;
        end
      end
      for (int n = 0; n < 3; n++) begin
        m_cnt[n] = nc[n];
        if (reg_wr && reg_addr == 8'(n*16 + 4))  m_rld[n] = reg_wdata;
        if (reg_wr && reg_addr == 8'(n*16 + 8))  m_c1[n]  = reg_wdata;
        if (reg_wr && reg_addr == 8'(n*16 + 12)) m_c2[n]  = reg_wdata;
      end
      if (reg_wr && reg_addr == 8'h30) m_ctrl = reg_wdata[11:0];
      if (reg_wr && reg_addr == 8'h38) m_mask = reg_wdata[8:0];
      m_st = ((reg_wr && reg_addr == 8'h34) ? (m_st & reg_wdata[8:0]) : m_st) | ev;
      h3 = h2; h2 = h1; h1 = ext_tick;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%h got=%h exp=%h t=%0t", tag, reg_addr, got, exp, $time);
    end
  endtask

  // compare every cycle, 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(cur_tag, reg_rdata, m_read(reg_addr));
      check("R10", {31'h0, irq}, {31'h0, m_irq()});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic watch(input logic [7:0] a, input int n);
    @(negedge clk);
    reg_addr = a;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R1 got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, explicit zero expectations
    cur_tag = "R1";
    foreach (m_cnt[i]) ;
    for (int a = 0; a < 'h40; a += 4) begin
      @(negedge clk); reg_addr = 8'(a);
      #1 check("R1", reg_rdata, 32'h0);
    end
    check("R1", {31'h0, irq}, 32'h0);

    // R2: map and readback, truncation, unmapped addresses
    cur_tag = "R2";
    for (int n = 0; n < 3; n++) begin
      wr(8'(n*16 + 4),  32'hA5A5_0000 + n);
      wr(8'(n*16 + 8),  32'h1234_5678 ^ n);
      wr(8'(n*16 + 12), 32'hDEAD_BEE0 + n);
      wr(8'(n*16),      32'h0000_0100 * (n + 1));
    end
    wr(8'h30, 32'hFFFF_F000);
    wr(8'h38, 32'hFFFF_FFFF);
    @(negedge clk); #1 check("R2", reg_rdata, 32'h0000_01FF);
    wr(8'h38, 32'h0);
    wr(8'h3C, 32'hFFFF_FFFF);
    @(negedge clk); #1 check("R2", reg_rdata, 32'h0);
    for (int a = 0; a < 'h40; a += 4) watch(8'(a), 1);
    watch(8'h02, 1); watch(8'h44, 1);

    // R3: channel 0 up-count each clock
    cur_tag = "R3";
    wr(8'h00, 32'd10);
    wr(8'h30, 32'h0000_0201);
    watch(8'h00, 20);

    // R4: wrap every 4 ticks, with irq enabled on wrap
    cur_tag = "R4";
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h0);
    wr(8'h04, 32'hFFFF_FFFC);
    wr(8'h00, 32'hFFFF_FFFC);
    wr(8'h38, 32'h0000_0004);
    wr(8'h30, 32'h0000_0205);
    watch(8'h00, 14);
    watch(8'h34, 3);
    wr(8'h34, 32'h0);
    watch(8'h34, 6);

    // R5: channel 1 counts down, reloads below zero
    cur_tag = "R5";
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h0);
    wr(8'h14, 32'd5);
    wr(8'h10, 32'd3);
    wr(8'h30, 32'h0000_0008);
    watch(8'h10, 14);
    watch(8'h34, 3);

    // R6: channel 2 compare hits
    cur_tag = "R6";
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h0);
    wr(8'h28, 32'd20);
    wr(8'h2C, 32'd25);
    wr(8'h20, 32'd15);
    wr(8'h30, 32'h0000_0840);
    watch(8'h34, 14);
    watch(8'h20, 3);

    // R7: software loads while running
    cur_tag = "R7";
    wr(8'h30, 32'h0000_0201);
    wr(8'h00, 32'h0000_0100);
    watch(8'h00, 3);
    wr(8'h00, 32'h0000_0008);
    wr(8'h00, 32'h0000_0008);
    watch(8'h00, 4);
    wr(8'h34, 32'h0);
    wr(8'h08, 32'h0000_0050);
    wr(8'h00, 32'h0000_0050);
    watch(8'h34, 2);

    // R8: external tick source on channel 0
    cur_tag = "R8";
    wr(8'h30, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h30, 32'h0000_0203);
    @(negedge clk); reg_addr = 8'h00;
    repeat (3) @(negedge clk);
    ext_tick = 1'b1; repeat (3) @(negedge clk);
    ext_tick = 1'b0; repeat (2) @(negedge clk);
    ext_tick = 1'b1; @(negedge clk);
    ext_tick = 1'b0; @(negedge clk);
    ext_tick = 1'b1; @(negedge clk);
    ext_tick = 1'b0; repeat (6) @(negedge clk);
    ext_tick = 1'b1; repeat (5) @(negedge clk);
    ext_tick = 1'b0; repeat (4) @(negedge clk);

    // R9: sticky status, selective clear, event over clear
    cur_tag = "R9";
    wr(8'h30, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h30, 32'h0000_0201);
    watch(8'h34, 3);
    wr(8'h34, 32'h0000_01FF);
    wr(8'h34, 32'h0);
    wr(8'h34, 32'h0);
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h0000_01FB);
    watch(8'h34, 3);

    // R10: mask and enable combinations
    cur_tag = "R10";
    wr(8'h38, 32'h0000_0001);
    wr(8'h30, 32'h0000_0004);
    wr(8'h38, 32'h0000_0004);
    wr(8'h30, 32'h0000_0000);
    wr(8'h30, 32'h0000_0020);
    wr(8'h38, 32'h0000_01FF);
    wr(8'h30, 32'h0000_0124);
    wr(8'h34, 32'h0);
    watch(8'h34, 3);

    // R11: disabled channels hold
    cur_tag = "R11";
    wr(8'h00, 32'h0000_0777);
    wr(8'h10, 32'h0000_0001);
    wr(8'h30, 32'h0000_0E00);
    watch(8'h00, 6);
    watch(8'h10, 6);
    watch(8'h34, 2);
    @(negedge clk); #1 check("R11", reg_rdata, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule